// File: doc/BRIEF.md
# Microcontroller Interrupt Controller

This block is the interrupt front end of a small 8-bit processor core. Events arrive from several sources and each one latches a flag. The core-side sources are an external pin, a change on a group of port pins, and a timer overflow. Six peripheral events (ADC done, two comparators, a second timer overflow, a timer match and a capture/compare event) latch flags in a separate peripheral flag register. Every flag has its own enable bit. A global enable gates all requests, and a peripheral enable additionally gates the peripheral group.

The core samples `irq_req` at each instruction boundary. When it accepts a request, the block does three things on the same clock edge: it clears the global enable, pulses a return-address push, and pulses a program-counter load with vector 0x0004. A return-from-interrupt strobe sets the global enable again. Software clears flags by writing 0 to them, and hardware never clears them. The external pin passes through a two-flop synchronizer followed by an edge detector whose polarity software selects. A pin that is configured as analog reads as 0 and raises no event. A separate `wake` output lets a sleeping core resume when an enabled external or port-change flag is set.

Top module: `mcu_irq_unit`

## Requirements
- R1: After reset, `ctl_q`, `pf_q`, `pe_q`, `irq_req`, `vec_load` and `ret_push` are all 0. The global enable is therefore off.
- R2: The `ctl_q` layout is as follows. Bit 7 is the global enable and bit 6 is the peripheral enable. Bits 5, 4 and 3 are the enables for the external pin, port change and timer. Bits 2, 1 and 0 are the matching flags in the same order. `irq_req` is 1 only when bit 7 is 1 and at least one flag has its enable set.
- R3: An event sets its flag on the next clock edge, whatever the state of the enables. If a software write lands in the same cycle, the event wins.
- R4: When `irq_req` and `insn_bound` are both 1, the next edge gives a one-cycle pulse on `vec_load` and `ret_push`. On that same edge `ctl_q[7]` goes to 0. `vec_addr` reads 0x0004.
- R5: A `retfie` pulse sets `ctl_q[7]` on the next edge.
- R6: Hardware never clears a flag. A flag that is still set re-raises `irq_req` once `retfie` runs.
- R7: When `edge_rise` is 1, a rising edge on `ext_pin` sets `ctl_q[2]`. When it is 0, a falling edge sets it. An edge of the other polarity has no effect.
- R8: A level change on `ext_pin` that is set up before clock edge k sets `ctl_q[2]` on edge k+2. The flag is visible after the third edge.
- R9: A pin with its analog bit set reads as 0 on `port_rd` and sets neither the edge flag nor the change flag.
- R10: `wake` is 1 when the external flag and its enable are both set, or when the change flag and its enable are both set. The global enable plays no part.
- R11: Suppose a write clears `ctl_q[7]` in the same cycle that a request meets `insn_bound`. Then no entry happens, the flag stays pending, and the request is raised again once the global enable returns.
- R12: The peripheral flags `pf_q` and enables `pe_q` (bit 0 is the ADC) raise `irq_req` only when `ctl_q[6]` and `ctl_q[7]` are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| ext_analog | input | 1 | External pin is configured as analog |
| edge_rise | input | 1 | 1 selects the rising edge, 0 the falling edge |
| port_pin | input | NPORT | Asynchronous port pins watched for change |
| port_analog | input | NPORT | Per-pin analog configuration |
| port_rd | output | NPORT | Synchronized digital read of the port |
| tmr0_evt | input | 1 | Timer overflow pulse |
| per_evt | input | NPER | Peripheral event pulses |
| ctl_we | input | 1 | Write strobe for the control/flag register |
| ctl_wdata | input | 8 | Control register write data |
| ctl_q | output | 8 | Control register contents |
| pf_we | input | 1 | Peripheral flag write strobe |
| pf_wdata | input | NPER | Peripheral flag write data |
| pf_q | output | NPER | Peripheral flags |
| pe_we | input | 1 | Peripheral enable write strobe |
| pe_wdata | input | NPER | Peripheral enable write data |
| pe_q | output | NPER | Peripheral enables |
| insn_bound | input | 1 | Core is at an instruction boundary |
| retfie | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the core |
| vec_load | output | 1 | Load the program counter with the vector |
| ret_push | output | 1 | Push the return address |
| vec_addr | output | PC_W | Interrupt vector |
| wake | output | 1 | Wake request for a sleeping core |

## Verification
The assertions assume that `insn_bound` and `retfie` are never 1 together, since the core cannot return while it is entering a handler. They also assume that all register writes, events and strobes change synchronously. The bench drives every input at the falling clock edge, raises `retfie` only while `insn_bound` is low, and changes the asynchronous pins only while the flags that the assertions track are already settled. The table rows keep `insn_bound` at 0, so each row measures flag and request logic with no entry happening.

// File: rtl/mcu_irq_unit.sv
module mcu_irq_unit #(
  parameter int NPORT = 6,
  parameter int NPER  = 6,
  parameter int PC_W  = 13,
  parameter logic [PC_W-1:0] VEC_ADDR = 'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin,
  input  logic              ext_analog,
  input  logic              edge_rise,
  input  logic [NPORT-1:0]  port_pin,
  input  logic [NPORT-1:0]  port_analog,
  output logic [NPORT-1:0]  port_rd,
  input  logic              tmr0_evt,
  input  logic [NPER-1:0]   per_evt,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_q,
  input  logic              pf_we,
  input  logic [NPER-1:0]   pf_wdata,
  output logic [NPER-1:0]   pf_q,
  input  logic              pe_we,
  input  logic [NPER-1:0]   pe_wdata,
  output logic [NPER-1:0]   pe_q,
  input  logic              insn_bound,
  input  logic              retfie,
  output logic              irq_req,
  output logic              vec_load,
  output logic              ret_push,
  output logic [PC_W-1:0]   vec_addr,
  output logic              wake
);
  localparam int GIE = 7, PIE = 6, EXT_F = 2, CHG_F = 1, TMR_F = 0;

  logic [2:0]       ext_s;
  logic [NPORT-1:0] p_s1, p_s2, p_s3;
  logic             ext_edge, chg_evt, core_hit, per_hit, gie_drop, take;
  logic [7:0]       ctl_nx;
  logic [NPER-1:0]  pf_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_s <= '0;
      p_s1  <= '0;
      p_s2  <= '0;
      p_s3  <= '0;
    end else begin
      ext_s <= {ext_s[1:0], ext_pin};
      p_s1  <= port_pin;
      p_s2  <= p_s1;
      p_s3  <= p_s2;
    end
  end

  assign ext_edge = ~ext_analog &
                    (edge_rise ? (ext_s[1] & ~ext_s[2]) : (~ext_s[1] & ext_s[2]));
  assign chg_evt  = |((p_s2 ^ p_s3) & ~port_analog);
  assign port_rd  = p_s2 & ~port_analog;

  assign core_hit = |(ctl_q[5:3] & ctl_q[2:0]);
  assign per_hit  = ctl_q[PIE] & |(pf_q & pe_q);
  assign irq_req  = ctl_q[GIE] & (core_hit | per_hit);
  assign gie_drop = ctl_we & ~ctl_wdata[GIE];
  assign take     = irq_req & insn_bound & ~gie_drop;

  always_comb begin
    ctl_nx = ctl_we ? ctl_wdata : ctl_q;
    if (retfie) ctl_nx[GIE] = 1'b1;
    if (take)   ctl_nx[GIE] = 1'b0;
    ctl_nx[EXT_F] = ctl_nx[EXT_F] | ext_edge;
    ctl_nx[CHG_F] = ctl_nx[CHG_F] | chg_evt;
    ctl_nx[TMR_F] = ctl_nx[TMR_F] | tmr0_evt;
  end

  assign pf_nx = (pf_we ? pf_wdata : pf_q) | per_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      pf_q     <= '0;
      pe_q     <= '0;
      vec_load <= 1'b0;
    end else begin
      ctl_q    <= ctl_nx;
      pf_q     <= pf_nx;
      if (pe_we) pe_q <= pe_wdata;
      vec_load <= take;
    end
  end

  assign ret_push = vec_load;
  assign vec_addr = VEC_ADDR;
  assign wake     = |(ctl_q[5:4] & ctl_q[2:1]);
endmodule

// File: rtl/mcu_irq_unit_chk.sv
module mcu_irq_unit_chk #(
  parameter int PC_W = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tmr0_evt,
  input logic            ctl_we,
  input logic [7:0]      ctl_wdata,
  input logic [7:0]      ctl_q,
  input logic            insn_bound,
  input logic            retfie,
  input logic            irq_req,
  input logic            vec_load,
  input logic            ret_push,
  input logic [PC_W-1:0] vec_addr,
  input logic            wake
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (ctl_q == 8'h00 && !vec_load));

  a_r4_entry_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |-> (!ctl_q[7] && ret_push && vec_addr == PC_W'(4)));

  a_r4_entry_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |-> $past(irq_req && insn_bound));

  a_r5_return_sets_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (retfie && !insn_bound) |=> ctl_q[7]);

  a_r3_flag_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    tmr0_evt |=> ctl_q[0]);

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0] && !ctl_we) |=> ctl_q[0]);

  a_r10_wake_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (ctl_q[5] || ctl_q[4]));

  a_r11_drop_blocks_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_bound && irq_req && ctl_we && !ctl_wdata[7]) |=> !vec_load);
endmodule

bind mcu_irq_unit mcu_irq_unit_chk #(.PC_W(PC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tmr0_evt(tmr0_evt), .ctl_we(ctl_we),
  .ctl_wdata(ctl_wdata), .ctl_q(ctl_q), .insn_bound(insn_bound),
  .retfie(retfie), .irq_req(irq_req), .vec_load(vec_load),
  .ret_push(ret_push), .vec_addr(vec_addr), .wake(wake)
);

// File: tb/mcu_irq_unit_tb_top.sv
module mcu_irq_unit_tb_top;
  localparam int NPORT = 6, NPER = 6, PC_W = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_pin = 0, ext_analog = 0, edge_rise = 1;
  logic [NPORT-1:0] port_pin = '0, port_analog = '0, port_rd;
  logic tmr0_evt = 0;
  logic [NPER-1:0] per_evt = '0;
  logic ctl_we = 0; logic [7:0] ctl_wdata = '0, ctl_q;
  logic pf_we = 0, pe_we = 0;
  logic [NPER-1:0] pf_wdata = '0, pe_wdata = '0, pf_q, pe_q;
  logic insn_bound = 0, retfie = 0;
  logic irq_req, vec_load, ret_push, wake;
  logic [PC_W-1:0] vec_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mcu_irq_unit #(.NPORT(NPORT), .NPER(NPER), .PC_W(PC_W)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  // {ctl, pen, tmr, pev, exp_req, exp_ctl, exp_pf}
  localparam logic [35:0] TBL [6] = '{
    {8'h00, 6'h00, 1'b1, 6'h00, 1'b0, 8'h01, 6'h00},
    {8'h88, 6'h00, 1'b1, 6'h00, 1'b1, 8'h89, 6'h00},
    {8'h08, 6'h00, 1'b1, 6'h00, 1'b0, 8'h09, 6'h00},
    {8'h80, 6'h3F, 1'b0, 6'h01, 1'b0, 8'h80, 6'h01},
    {8'hC0, 6'h01, 1'b0, 6'h01, 1'b1, 8'hC0, 6'h01},
    {8'hC0, 6'h02, 1'b0, 6'h01, 1'b0, 8'hC0, 6'h01}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ctl", ctl_q, 0); chk("R1 pf", pf_q, 0); chk("R1 pe", pe_q, 0);
    chk("R1 req", irq_req, 0); chk("R1 vec", vec_load, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R12 table
    foreach (TBL[i]) begin
      logic [35:0] e;
      e = TBL[i];
      @(negedge clk);
      ctl_we = 1; ctl_wdata = e[35:28];
      pe_we = 1; pe_wdata = e[27:22];
      pf_we = 1; pf_wdata = '0;
      @(negedge clk);
      ctl_we = 0; pe_we = 0; pf_we = 0;
      tmr0_evt = e[21]; per_evt = e[20:15];
      @(negedge clk);
      tmr0_evt = 0; per_evt = '0;
      chk($sformatf("R2/R12 row%0d req", i), irq_req, e[14]);
      chk($sformatf("R3 row%0d ctl", i), ctl_q, e[13:6]);
      chk($sformatf("R3 row%0d pf", i), pf_q, e[5:0]);
    end

    // R3: event beats simultaneous clearing write
    @(negedge clk); ctl_we = 1; ctl_wdata = 8'h00; tmr0_evt = 1;
    @(negedge clk); ctl_we = 0; tmr0_evt = 0;
    chk("R3 event wins", ctl_q[0], 1);

    // R4 R5 R6: entry and return
    wr_ctl(8'h88);
    @(negedge clk); tmr0_evt = 1;
    @(negedge clk); tmr0_evt = 0;
    chk("R2 req pending", irq_req, 1);
    insn_bound = 1;
    @(negedge clk); insn_bound = 0;
    chk("R4 vec_load", vec_load, 1); chk("R4 ret_push", ret_push, 1);
    chk("R4 vec_addr", vec_addr, 4); chk("R4 gie cleared", ctl_q[7], 0);
    chk("R6 flag kept", ctl_q[0], 1);
    @(negedge clk);
    chk("R4 one pulse", vec_load, 0);
    retfie = 1;
    @(negedge clk); retfie = 0;
    chk("R5 gie set", ctl_q[7], 1); chk("R6 retrigger", irq_req, 1);

    // R11: clearing write blocks entry, request kept
    ctl_we = 1; ctl_wdata = 8'h09; insn_bound = 1;
    @(negedge clk); ctl_we = 0; insn_bound = 0;
    chk("R11 no entry", vec_load, 0); chk("R11 flag pending", ctl_q[0], 1);
    retfie = 1;
    @(negedge clk); retfie = 0;
    chk("R11 re-raised", irq_req, 1);

    // R7 R8: external edge and latency
    wr_ctl(8'h20); edge_rise = 1;
    @(negedge clk); ext_pin = 1;
    @(negedge clk);
    @(negedge clk); chk("R8 not yet", ctl_q[2], 0);
    @(negedge clk); chk("R8 third edge", ctl_q[2], 1);
    wr_ctl(8'h20);
    ext_pin = 0; repeat (4) @(negedge clk);
    chk("R7 wrong polarity", ctl_q[2], 0);
    edge_rise = 0;
    ext_pin = 1; repeat (4) @(negedge clk);
    chk("R7 rise ignored when falling", ctl_q[2], 0);
    ext_pin = 0; repeat (4) @(negedge clk);
    chk("R7 falling edge", ctl_q[2], 1);

    // R10 wake
    chk("R10 wake on", wake, 1);
    wr_ctl(8'h04);
    chk("R10 wake gated", wake, 0);

    // R9 analog pins
    ext_analog = 1; edge_rise = 1; port_analog = 6'b000001;
    wr_ctl(8'h30);
    ext_pin = 1; port_pin = 6'b000001; repeat (4) @(negedge clk);
    chk("R9 no ext flag", ctl_q[2], 0); chk("R9 no chg flag", ctl_q[1], 0);
    chk("R9 reads zero", port_rd, 0);
    port_pin = 6'b000011; repeat (4) @(negedge clk);
    chk("R9 digital change", ctl_q[1], 1); chk("R9 digital read", port_rd, 6'b000010);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule